// File: doc/BRIEF.md
# Three-Anchor Range Position Solver

The block turns three ranging measurements into a planar position estimate. It receives the coordinates of three fixed anchors and the measured range from the unknown point to each of them, and returns one X and one Y coordinate. Internally, the circle equation of the first anchor is subtracted from those of the second and third. This leaves two linear equations, A·x + B·y = C and D·x + E·y = F, which are solved by Cramer's rule.

All arithmetic is exact signed integer arithmetic in an internal word four times the port width. A fixed micro-sequence issues one operation per cycle to a single shared add/subtract unit and a single shared multiply/divide unit. The two final divisions use a restoring divider that produces one quotient bit per cycle. A caller pulses start, waits for the one-cycle done pulse, and reads the registered result. When the three anchors lie on one line, an error flag is raised in place of a new result.

Top module: `pos_solver`

## Requirements
- R1: With A=2(x2−x1), B=2(y2−y1), D=2(x3−x1), E=2(y3−y1), Ki=xi²+yi²−ri², C=K2−K1, F=K3−K1 and det=A·E−B·D≠0, pos_x_o equals the low 12 bits of (C·E−B·F)/det.
- R2: Under the same conditions, pos_y_o equals the low 12 bits of (A·F−C·D)/det.
- R3: A start_i seen while idle captures all nine operand inputs. Changes on those inputs after that cycle have no effect on the result.
- R4: busy_o is high from the cycle after an accepted start until the result is presented. done_o is high for exactly one cycle and only while busy_o is low.
- R5: start_i is ignored while busy_o is high. No second result and no change of operands follows from it.
- R6: When det is zero, done_o pulses with err_o=1, and pos_x_o and pos_y_o keep their previous values.
- R7: err_o stays at its last value until the next done_o pulse, and it is cleared by a successful solve.
- R8: The number of cycles from an accepted start to done_o is the same for every operand set that yields a result. The determinant-zero path also has a fixed latency, which is shorter.
- R9: Both divisions round toward zero, so a negative quotient is the negated quotient of the magnitudes.
- R10: After reset, pos_x_o=0, pos_y_o=0, and done_o, err_o and busy_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only while idle |
| anc_x1_i | input | 12 | Anchor 1 X, signed |
| anc_y1_i | input | 12 | Anchor 1 Y, signed |
| anc_x2_i | input | 12 | Anchor 2 X, signed |
| anc_y2_i | input | 12 | Anchor 2 Y, signed |
| anc_x3_i | input | 12 | Anchor 3 X, signed |
| anc_y3_i | input | 12 | Anchor 3 Y, signed |
| rng1_i | input | 12 | Range to anchor 1 |
| rng2_i | input | 12 | Range to anchor 2 |
| rng3_i | input | 12 | Range to anchor 3 |
| busy_o | output | 1 | Solve in progress |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Last solve found a zero determinant |
| pos_x_o | output | 12 | Solved X, signed |
| pos_y_o | output | 12 | Solved Y, signed |

## Verification
A wrong micro-step, such as a swapped operand or a bad destination register, corrupts one of the coefficients. Because the operands are random and arithmetic is exact, the first solve then returns a wrong X or Y, about 130 cycles after start. A divider that rounds or handles signs wrongly appears on any negative quotient. A sequencer that mis-counts shows up as a change in latency between solves. A bad busy or error path shows up in the first collinear case or the first start issued mid-solve, either as an extra done pulse or as outputs that move when they should hold.

// File: rtl/pos_solver_pkg.sv
package pos_solver_pkg;

  typedef enum logic [4:0] {
    R_X1, R_Y1, R_X2, R_Y2, R_X3, R_Y3, R_D1, R_D2, R_D3,
    R_A, R_B, R_C, R_D, R_E, R_F, R_K, R_T, R_U, R_DET, R_NX, R_NY
  } reg_e;

  localparam int NREG  = 21;
  localparam int NSTEP = 34;
  localparam int SW    = $clog2(NSTEP);

  typedef enum logic [1:0] {OP_ADD, OP_SUB, OP_MUL} op_e;

  typedef struct packed {
    op_e  op;
    reg_e a;
    reg_e b;
    reg_e d;
  } uop_t;

  function automatic uop_t mk(input op_e op, input reg_e a, input reg_e b, input reg_e d);
    uop_t u;
    u.op = op; u.a = a; u.b = b; u.d = d;
    return u;
  endfunction

  // linearised system: rows (A,B|C) and (D,E|F), then det and numerators
  function automatic uop_t ucode(input logic [SW-1:0] s);
    case (s)
      6'd0:  return mk(OP_SUB, R_X2, R_X1, R_A);
      6'd1:  return mk(OP_ADD, R_A,  R_A,  R_A);
      6'd2:  return mk(OP_SUB, R_Y2, R_Y1, R_B);
      6'd3:  return mk(OP_ADD, R_B,  R_B,  R_B);
      6'd4:  return mk(OP_SUB, R_X3, R_X1, R_D);
      6'd5:  return mk(OP_ADD, R_D,  R_D,  R_D);
      6'd6:  return mk(OP_SUB, R_Y3, R_Y1, R_E);
      6'd7:  return mk(OP_ADD, R_E,  R_E,  R_E);
      6'd8:  return mk(OP_MUL, R_X1, R_X1, R_T);
      6'd9:  return mk(OP_MUL, R_Y1, R_Y1, R_U);
      6'd10: return mk(OP_ADD, R_T,  R_U,  R_T);
      6'd11: return mk(OP_MUL, R_D1, R_D1, R_U);
      6'd12: return mk(OP_SUB, R_T,  R_U,  R_K);
      6'd13: return mk(OP_MUL, R_X2, R_X2, R_T);
      6'd14: return mk(OP_MUL, R_Y2, R_Y2, R_U);
      6'd15: return mk(OP_ADD, R_T,  R_U,  R_T);
      6'd16: return mk(OP_MUL, R_D2, R_D2, R_U);
      6'd17: return mk(OP_SUB, R_T,  R_U,  R_T);
      6'd18: return mk(OP_SUB, R_T,  R_K,  R_C);
      6'd19: return mk(OP_MUL, R_X3, R_X3, R_T);
      6'd20: return mk(OP_MUL, R_Y3, R_Y3, R_U);
      6'd21: return mk(OP_ADD, R_T,  R_U,  R_T);
      6'd22: return mk(OP_MUL, R_D3, R_D3, R_U);
      6'd23: return mk(OP_SUB, R_T,  R_U,  R_T);
      6'd24: return mk(OP_SUB, R_T,  R_K,  R_F);
      6'd25: return mk(OP_MUL, R_A,  R_E,  R_T);
      6'd26: return mk(OP_MUL, R_B,  R_D,  R_U);
      6'd27: return mk(OP_SUB, R_T,  R_U,  R_DET);
      6'd28: return mk(OP_MUL, R_C,  R_E,  R_T);
      6'd29: return mk(OP_MUL, R_B,  R_F,  R_U);
      6'd30: return mk(OP_SUB, R_T,  R_U,  R_NX);
      6'd31: return mk(OP_MUL, R_A,  R_F,  R_T);
      6'd32: return mk(OP_MUL, R_C,  R_D,  R_U);
      6'd33: return mk(OP_SUB, R_T,  R_U,  R_NY);
      default: return mk(OP_ADD, R_T, R_T, R_T);
    endcase
  endfunction

endpackage

// File: rtl/pos_addsub.sv
module pos_addsub #(
  parameter int WW = 48
) (
  input  logic signed [WW-1:0] a_i,
  input  logic signed [WW-1:0] b_i,
  input  logic                 sub_i,
  output logic signed [WW-1:0] res_o
);
  assign res_o = sub_i ? (a_i - b_i) : (a_i + b_i);
endmodule

// File: rtl/pos_rdiv.sv
module pos_rdiv #(
  parameter int WW = 48
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic signed [WW-1:0] num_i,
  input  logic signed [WW-1:0] den_i,
  output logic signed [WW-1:0] quo_o,
  output logic signed [WW-1:0] rem_o,
  output logic                 busy_o,
  output logic                 done_o
);
  localparam int CW = $clog2(WW + 1);

  logic [WW-1:0] q_q, dv_q, mag_n, mag_d;
  logic [WW:0]   r_q, shifted, trial;
  logic [CW-1:0] cnt_q;
  logic          negq_q, negr_q, busy_q, done_q;

  assign mag_n   = num_i[WW-1] ? -num_i : num_i;
  assign mag_d   = den_i[WW-1] ? -den_i : den_i;
  assign shifted = {r_q[WW-1:0], q_q[WW-1]};
  assign trial   = shifted - {1'b0, dv_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0; r_q <= '0; dv_q <= '0; cnt_q <= '0;
      negq_q <= 1'b0; negr_q <= 1'b0; busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        q_q    <= mag_n;
        r_q    <= '0;
        dv_q   <= mag_d;
        negq_q <= num_i[WW-1] ^ den_i[WW-1];
        negr_q <= num_i[WW-1];
        cnt_q  <= CW'(WW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        // restoring step: keep the trial remainder only if it did not borrow
        if (!trial[WW]) begin
          r_q <= trial;
          q_q <= {q_q[WW-2:0], 1'b1};
        end else begin
          r_q <= shifted;
          q_q <= {q_q[WW-2:0], 1'b0};
        end
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign quo_o  = negq_q ? -q_q : q_q;
  assign rem_o  = negr_q ? -r_q[WW-1:0] : r_q[WW-1:0];
  assign busy_o = busy_q;
  assign done_o = done_q;

  a_r9_rem_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (r_q < {1'b0, dv_q}) || (dv_q == '0));

  a_r8_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !start_i);

endmodule

// File: rtl/pos_muldiv.sv
module pos_muldiv #(
  parameter int WW = 48
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [WW-1:0] a_i,
  input  logic signed [WW-1:0] b_i,
  output logic signed [WW-1:0] prod_o,
  input  logic                 div_start_i,
  output logic signed [WW-1:0] quo_o,
  output logic signed [WW-1:0] rem_o,
  output logic                 div_busy_o,
  output logic                 div_done_o
);
  assign prod_o = a_i * b_i;

  pos_rdiv #(.WW(WW)) u_rdiv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(div_start_i),
    .num_i  (a_i),
    .den_i  (b_i),
    .quo_o  (quo_o),
    .rem_o  (rem_o),
    .busy_o (div_busy_o),
    .done_o (div_done_o)
  );
endmodule

// File: rtl/pos_solver.sv
module pos_solver
  import pos_solver_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic signed [DW-1:0] anc_x1_i,
  input  logic signed [DW-1:0] anc_y1_i,
  input  logic signed [DW-1:0] anc_x2_i,
  input  logic signed [DW-1:0] anc_y2_i,
  input  logic signed [DW-1:0] anc_x3_i,
  input  logic signed [DW-1:0] anc_y3_i,
  input  logic signed [DW-1:0] rng1_i,
  input  logic signed [DW-1:0] rng2_i,
  input  logic signed [DW-1:0] rng3_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 err_o,
  output logic signed [DW-1:0] pos_x_o,
  output logic signed [DW-1:0] pos_y_o
);
  localparam int WW = 4 * DW;

  typedef enum logic [2:0] {S_IDLE, S_RUN, S_CHK, S_DIVX, S_DIVY} state_e;

  state_e              state_q;
  logic [SW-1:0]       step_q;
  logic signed [WW-1:0] rf [NREG];
  uop_t                uop;
  logic signed [WW-1:0] op_a, op_b, sum, prod, quo, rem, wb;
  logic                div_start, div_busy, div_done, det_nz;
  logic                done_q, err_q;
  logic signed [DW-1:0] x_q, y_q;

  function automatic logic signed [WW-1:0] sx(input logic signed [DW-1:0] v);
    return WW'(v);
  endfunction

  assign uop    = ucode(step_q);
  assign det_nz = |rf[R_DET];

  always_comb begin
    if (state_q == S_RUN) begin
      op_a = rf[uop.a];
      op_b = rf[uop.b];
    end else begin
      op_a = (state_q == S_CHK) ? rf[R_NX] : rf[R_NY];
      op_b = rf[R_DET];
    end
  end

  pos_addsub #(.WW(WW)) u_addsub (
    .a_i  (op_a),
    .b_i  (op_b),
    .sub_i(uop.op == OP_SUB),
    .res_o(sum)
  );

  pos_muldiv #(.WW(WW)) u_muldiv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .a_i        (op_a),
    .b_i        (op_b),
    .prod_o     (prod),
    .div_start_i(div_start),
    .quo_o      (quo),
    .rem_o      (rem),
    .div_busy_o (div_busy),
    .div_done_o (div_done)
  );

  assign wb        = (uop.op == OP_MUL) ? prod : sum;
  assign div_start = ((state_q == S_CHK) && det_nz) || ((state_q == S_DIVX) && div_done);

  // register bank: operands loaded on accept, temporaries by the micro-sequence
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (state_q == S_IDLE && start_i) begin
      rf[R_X1] <= sx(anc_x1_i);
      rf[R_Y1] <= sx(anc_y1_i);
      rf[R_X2] <= sx(anc_x2_i);
      rf[R_Y2] <= sx(anc_y2_i);
      rf[R_X3] <= sx(anc_x3_i);
      rf[R_Y3] <= sx(anc_y3_i);
      rf[R_D1] <= sx(rng1_i);
      rf[R_D2] <= sx(rng2_i);
      rf[R_D3] <= sx(rng3_i);
    end else if (state_q == S_RUN) begin
      rf[uop.d] <= wb;
    end else if (state_q == S_DIVX && div_done) begin
      rf[R_T] <= quo;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      x_q     <= '0;
      y_q     <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_RUN;
          step_q  <= '0;
        end
        S_RUN: begin
          step_q <= step_q + SW'(1);
          if (step_q == SW'(NSTEP - 1)) state_q <= S_CHK;
        end
        S_CHK: begin
          if (!det_nz) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
            err_q   <= 1'b1;
          end else begin
            state_q <= S_DIVX;
          end
        end
        S_DIVX: if (div_done) state_q <= S_DIVY;
        S_DIVY: if (div_done) begin
          state_q <= S_IDLE;
          x_q     <= rf[R_T][DW-1:0];
          y_q     <= quo[DW-1:0];
          err_q   <= 1'b0;
          done_q  <= 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != S_IDLE);
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign pos_x_o = x_q;
  assign pos_y_o = y_q;

  a_r4_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r4_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r6_err_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> ($stable(pos_x_o) && $stable(pos_y_o)));

  a_r3_inputs_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable({rf[R_X1], rf[R_Y1], rf[R_X2], rf[R_Y2], rf[R_X3],
                        rf[R_Y3], rf[R_D1], rf[R_D2], rf[R_D3]}));

  a_r8_div_idle_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RUN) |-> !div_busy);

endmodule

// File: tb/pos_solver_bench.sv
module pos_solver_bench;
  localparam int CLK_NS = 10;
  localparam int LIMIT  = 1000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic signed [11:0] ax1, ay1, ax2, ay2, ax3, ay3, r1, r2, r3;
  logic busy, done, err;
  logic signed [11:0] px, py;

  int n_chk = 0, n_bad = 0;
  int ref_lat = -1, err_lat = -1;
  logic [11:0] last_x = '0, last_y = '0;

  always #(CLK_NS / 2) clk = ~clk;

  pos_solver u_pos_solver (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .anc_x1_i(ax1), .anc_y1_i(ay1), .anc_x2_i(ax2), .anc_y2_i(ay2),
    .anc_x3_i(ax3), .anc_y3_i(ay3), .rng1_i(r1), .rng2_i(r2), .rng3_i(r3),
    .busy_o(busy), .done_o(done), .err_o(err), .pos_x_o(px), .pos_y_o(py)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void model(input longint x1, y1, x2, y2, x3, y3, d1, d2, d3,
                                output logic [11:0] ex, output logic [11:0] ey,
                                output bit zero, output bit neg);
    longint a, b, d, e, k1, k2, k3, c, f, det, nx, ny, qx, qy;
    a = 2 * (x2 - x1); b = 2 * (y2 - y1);
    d = 2 * (x3 - x1); e = 2 * (y3 - y1);
    k1 = x1 * x1 + y1 * y1 - d1 * d1;
    k2 = x2 * x2 + y2 * y2 - d2 * d2;
    k3 = x3 * x3 + y3 * y3 - d3 * d3;
    c = k2 - k1; f = k3 - k1;
    det = a * e - b * d;
    nx = c * e - b * f;
    ny = a * f - c * d;
    zero = (det == 0);
    ex = '0; ey = '0; neg = 1'b0;
    if (!zero) begin
      qx = nx / det; qy = ny / det;
      ex = qx[11:0]; ey = qy[11:0];
      neg = (qx < 0) || (qy < 0);
    end
  endfunction

  task automatic drive(input int x1, y1, x2, y2, x3, y3, d1, d2, d3);
    ax1 = 12'(x1); ay1 = 12'(y1); ax2 = 12'(x2); ay2 = 12'(y2);
    ax3 = 12'(x3); ay3 = 12'(y3); r1 = 12'(d1); r2 = 12'(d2); r3 = 12'(d3);
  endtask

  task automatic scramble();
    drive($urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
          $urandom, $urandom, $urandom);
  endtask

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done && lat < LIMIT) begin
      @(negedge clk);
      lat++;
    end
    chk(done, "R4", "done pulse seen", done, 1);
  endtask

  task automatic run_case(input int x1, y1, x2, y2, x3, y3, d1, d2, d3);
    logic [11:0] ex, ey;
    bit zero, neg;
    int lat;
    model(x1, y1, x2, y2, x3, y3, d1, d2, d3, ex, ey, zero, neg);
    @(negedge clk);
    drive(x1, y1, x2, y2, x3, y3, d1, d2, d3);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    scramble();  // R3: post-accept input changes must not matter
    chk(busy, "R4", "busy after start", busy, 1);
    wait_done(lat);
    if (zero) begin
      chk(err, "R6", "err on zero det", err, 1);
      chk(px == last_x, "R6", "x held", px, last_x);
      chk(py == last_y, "R6", "y held", py, last_y);
      if (err_lat < 0) err_lat = lat;
      else chk(lat == err_lat, "R8", "error-path latency", lat, err_lat);
    end else begin
      chk(!err, "R7", "err cleared", err, 0);
      chk(px == ex, neg ? "R9" : "R1", "x result", px, ex);
      chk(py == ey, neg ? "R9" : "R2", "y result", py, ey);
      last_x = ex; last_y = ey;
      if (ref_lat < 0) ref_lat = lat;
      else chk(lat == ref_lat, "R8", "solve latency", lat, ref_lat);
    end
    @(negedge clk);
    chk(!done, "R4", "done one cycle", done, 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(px == 0 && py == 0, "R10", "reset position", {px, py}, 0);
    chk(!done && !err && !busy, "R10", "reset flags", {done, err, busy}, 0);

    // directed: true point (3,4), then a shifted copy at (-97,-196)
    run_case(0, 0, 6, 0, 0, 8, 5, 5, 5);
    chk(px == 3 && py == 4, "R1", "directed point", {px, py}, {12'd3, 12'd4});
    run_case(-100, -200, -94, -200, -100, -192, 5, 5, 5);
    chk(px == -12'sd97 && py == -12'sd196, "R2", "shifted point",
        {px, py}, {-12'sd97, -12'sd196});

    // collinear anchors, then recovery
    run_case(0, 0, 10, 10, 20, 20, 7, 9, 11);
    chk(err, "R7", "err held until next done", err, 1);
    run_case(0, 0, 6, 0, 0, 8, 5, 5, 5);
    run_case(5, 5, 5, 40, 5, -30, 3, 4, 5);

    // R5: start while busy is ignored
    begin
      int lat;
      @(negedge clk);
      drive(0, 0, 6, 0, 0, 8, 5, 5, 5);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      drive(50, 60, -70, 80, 90, -10, 11, 22, 33);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(lat);
      chk(px == 3 && py == 4, "R5", "first operands kept", {px, py}, {12'd3, 12'd4});
      chk(lat + 11 == ref_lat, "R5", "no restart latency", lat + 11, ref_lat);
      begin
        bit extra = 1'b0;
        for (int i = 0; i < 200; i++) begin
          @(negedge clk);
          if (done || busy) extra = 1'b1;
        end
        chk(!extra, "R5", "no second solve", extra, 0);
      end
      last_x = 12'd3; last_y = 12'd4;
    end

    // constrained random
    void'($urandom(32'd1234));
    for (int n = 0; n < 300; n++) begin
      int sp;
      sp = (n % 3 == 0) ? 4096 : ((n % 3 == 1) ? 256 : 32);
      run_case(int'($urandom % sp) - sp / 2, int'($urandom % sp) - sp / 2,
               int'($urandom % sp) - sp / 2, int'($urandom % sp) - sp / 2,
               int'($urandom % sp) - sp / 2, int'($urandom % sp) - sp / 2,
               int'($urandom % (sp / 2)), int'($urandom % (sp / 2)),
               int'($urandom % (sp / 2)));
    end
    // a few more degenerate cases
    run_case(-300, 100, -300, 200, -300, -400, 10, 20, 30);
    run_case(7, 7, 7, 7, 100, 3, 1, 1, 1);
    finish_run();
  end
endmodule